// File: doc/BRIEF.md
# Video Controller CPU Register Port

This block sits between a host CPU's byte-wide bus and a tile-and-sprite video controller. The host first selects one of 32 internal register slots through an index write. It then writes the chosen 16-bit register one byte at a time, or moves words to and from video RAM. Video RAM is reached through two address pointers: one for writes and one for reads. Each pointer steps forward by itself after an access, by a stride taken from the control register, so the host can stream a row or a column of the tile map without reloading the address.

Some high-byte writes do more than store data. A high-byte write to the data slot sends a full word to video RAM. A high-byte write to the transfer-length slot fires a one-cycle start pulse for the RAM-to-RAM copier. A high-byte write to the sprite-table base marks the sprite-table transfer as complete.

Event flags arrive from the renderer and the copier and collect in a sticky status word. A status read returns only the enabled flags, and clears exactly the flags it returned.

Top module: `vidRegPort`

## Requirements
- R1: A write at port offset 0 loads the register index from the low 5 bits of the byte. Bits 7:5 are dropped, so 0xE1 selects index 1.
- R2: Writes at offset 2 and offset 3 load the low and high byte of the selected register. Index 0 is the RAM write pointer, index 1 is the RAM read pointer, index 2 is the data word, index 5 is control, index 0x0F is copy control, index 0x12 is the copy length and index 0x13 is the sprite-table base. A byte goes only to the bits that register defines.
- R3: A high-byte write at index 2 raises `ramWrReq`. The request carries the word {high byte, last low byte} at the current write pointer. It holds data and address stable until `ramReady`, and is then dropped.
- R4: Control bits 12:11, which are high-byte bits 4:3 at index 5, set the pointer stride: 0 gives 1, 1 gives 32, 2 gives 64 and 3 gives 128. The write pointer advances by this stride when a RAM write is accepted.
- R5: A read at offset 2 returns bits 7:0 of the RAM word at the read pointer. A read at offset 3 returns bits 15:8, and the read pointer then advances by the stride.
- R6: Only a high-byte write at index 0x12 gives a single-cycle `dmaStart` pulse, in the cycle after the write. A low-byte write there gives none.
- R7: A high-byte write at index 0x13 sets status bit 3 (sprite-table transfer done).
- R8: The enable mask maps control bits 0, 1 and 2 to status bits 0, 1 and 2, control bit 3 to status bit 5, and copy-control bits 0 and 1 to status bits 3 and 4. A read at offset 0 returns status AND mask and clears exactly those bits.
- R9: A read at offset 1 returns 0. A write at offset 1 changes no pointer, register or flag.
- R10: Both pointers are 16 bits wide and wrap modulo 2^16 when they advance.
- R11: A bit set on `evtIn` for one cycle sets the matching status bit. The bit stays set until a status read clears it, even while its enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| portOfs | input | 2 | CPU port offset (0 index/status, 1 unused, 2 low byte, 3 high byte) |
| wrEn | input | 1 | CPU write strobe, one cycle per access |
| rdEn | input | 1 | CPU read strobe, one cycle per access |
| wrData | input | 8 | CPU write byte |
| rdData | output | 8 | CPU read byte, valid in the cycle `rdEn` is high |
| evtIn | input | 6 | Event set pulses from renderer and copier |
| ramWrReq | output | 1 | RAM write request |
| ramReady | input | 1 | RAM accepts the pending write this cycle |
| ramWrAddr | output | 16 | RAM write pointer / request address |
| ramWrData | output | 16 | RAM write word |
| ramRdAddr | output | 16 | RAM read pointer |
| ramRdWord | input | 16 | RAM word at `ramRdAddr`, combinational |
| dmaStart | output | 1 | One-cycle start pulse for RAM-to-RAM copy |

## Verification
The assertions assume the following about the host and the RAM:
- Each access is a one-cycle strobe, and `wrEn` and `rdEn` are never high together.
- While a RAM write waits for `ramReady`, the host neither issues another data high-byte write nor reloads the write pointer.
- High-byte writes to the copy-length slot are never issued in consecutive cycles.
- The status-clear property is only claimed in cycles where `evtIn` is quiet.

The directed stimulus keeps within these limits. It leaves an idle cycle after every access, waits for acceptance before the next data word, and pulses events only apart from status reads.

// File: rtl/vid_reg_port_pkg.sv
package vid_reg_port_pkg;
  localparam int IDX_W  = 5;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int EVT_W  = 6;
  localparam int STEP_W = 2;

  localparam logic [1:0] OFS_INDEX = 2'd0;
  localparam logic [1:0] OFS_LO    = 2'd2;
  localparam logic [1:0] OFS_HI    = 2'd3;

  localparam logic [IDX_W-1:0] REG_WPTR    = 5'h00;
  localparam logic [IDX_W-1:0] REG_RPTR    = 5'h01;
  localparam logic [IDX_W-1:0] REG_DATA    = 5'h02;
  localparam logic [IDX_W-1:0] REG_CTRL    = 5'h05;
  localparam logic [IDX_W-1:0] REG_CPYCTL  = 5'h0F;
  localparam logic [IDX_W-1:0] REG_CPYLEN  = 5'h12;
  localparam logic [IDX_W-1:0] REG_SPRBASE = 5'h13;

  localparam int EVT_SPRDONE = 3;

  typedef struct packed {
    logic             wrLo;
    logic             wrHi;
    logic             rdLo;
    logic             rdHi;
    logic             rdStat;
    logic [IDX_W-1:0] idx;
  } portStrobe_t;
endpackage

// File: rtl/vidRegPortCtrl.sv
module vidRegPortCtrl
  import vid_reg_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       portOfs,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] wrIdx,
  output portStrobe_t      strobe
);
  logic [IDX_W-1:0] idxReg;

  // index register: only the low bits of the byte survive (R1)
  always_ff @(posedge clk) begin
    if (!rst_n)                            idxReg <= '0;
    else if (wrEn && portOfs == OFS_INDEX) idxReg <= wrIdx;
  end

  // offset 1 decodes to no strobe at all (R9)
  always_comb begin
    strobe.idx    = idxReg;
    strobe.wrLo   = wrEn && (portOfs == OFS_LO);
    strobe.wrHi   = wrEn && (portOfs == OFS_HI);
    strobe.rdLo   = rdEn && !wrEn && (portOfs == OFS_LO);
    strobe.rdHi   = rdEn && !wrEn && (portOfs == OFS_HI);
    strobe.rdStat = rdEn && !wrEn && (portOfs == OFS_INDEX);
  end
endmodule

// File: rtl/vidRegPortData.sv
module vidRegPortData
  import vid_reg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  portStrobe_t       strobe,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic [EVT_W-1:0]  evtIn,
  output logic              ramWrReq,
  input  logic              ramReady,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [ADDR_W-1:0] ramWrData,
  output logic [ADDR_W-1:0] ramRdAddr,
  input  logic [ADDR_W-1:0] ramRdWord,
  output logic              dmaStart
);
  logic [ADDR_W-1:0] wrPtr, rdPtr, step;
  logic [BYTE_W-1:0] dataLo;
  logic [3:0]        evtEn;
  logic [1:0]        cpyEn;
  logic [STEP_W-1:0] stepSel;
  logic [EVT_W-1:0]  status, evMask, clrBits, setBits;

  // stride: 1, 32, 64, 128 (R4)
  assign step   = (stepSel == '0) ? ADDR_W'(1) : (ADDR_W'(16) << stepSel);
  // control bit 3 drives status bit 5, copy-control drives bits 3/4 (R8)
  assign evMask = {evtEn[3], cpyEn[1], cpyEn[0], evtEn[2:0]};

  assign ramWrAddr = wrPtr;
  assign ramRdAddr = rdPtr;

  always_comb begin
    clrBits = strobe.rdStat ? (status & evMask) : '0;
    setBits = evtIn;
    if (strobe.wrHi && strobe.idx == REG_SPRBASE) setBits[EVT_SPRDONE] = 1'b1;
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdStat) rdData = BYTE_W'(status & evMask);
    if (strobe.rdLo)   rdData = ramRdWord[BYTE_W-1:0];
    if (strobe.rdHi)   rdData = ramRdWord[ADDR_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0; rdPtr <= '0; dataLo <= '0; evtEn <= '0; cpyEn <= '0;
      stepSel <= '0; status <= '0; ramWrReq <= 1'b0; ramWrData <= '0;
      dmaStart <= 1'b0;
    end else begin
      dmaStart <= 1'b0;
      status   <= (status & ~clrBits) | setBits;
      if (ramWrReq && ramReady) begin
        ramWrReq <= 1'b0;
        wrPtr    <= wrPtr + step;               // wraps mod 2^16 (R10)
      end
      if (strobe.rdHi) rdPtr <= rdPtr + step;
      if (strobe.wrLo) begin
        case (strobe.idx)
          REG_WPTR:   wrPtr[BYTE_W-1:0] <= wrData;
          REG_RPTR:   rdPtr[BYTE_W-1:0] <= wrData;
          REG_DATA:   dataLo <= wrData;
          REG_CTRL:   evtEn <= wrData[3:0];
          REG_CPYCTL: cpyEn <= wrData[1:0];
          default: ;
        endcase
      end
      if (strobe.wrHi) begin
        case (strobe.idx)
          REG_WPTR: wrPtr[ADDR_W-1:BYTE_W] <= wrData;
          REG_RPTR: rdPtr[ADDR_W-1:BYTE_W] <= wrData;
          REG_DATA: begin
            ramWrReq  <= 1'b1;
            ramWrData <= {wrData, dataLo};
          end
          REG_CTRL:   stepSel <= wrData[4:3];
          REG_CPYLEN: dmaStart <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ramWrReq && !ramReady |=> ramWrReq && $stable(ramWrAddr) && $stable(ramWrData)); // R3

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ramWrReq && ramReady && !strobe.wrLo && !strobe.wrHi |=>
      (ADDR_W'(ramWrAddr - $past(ramWrAddr)) inside {16'd1, 16'd32, 16'd64, 16'd128})); // R4

  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rdHi |=>
      (ADDR_W'(ramRdAddr - $past(ramRdAddr)) inside {16'd1, 16'd32, 16'd64, 16'd128})); // R5

  AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dmaStart |=> !dmaStart); // R6

  AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rdStat && evtIn == '0 |=> (status & $past(status & evMask)) == '0); // R8
endmodule

// File: rtl/vidRegPort.sv
module vidRegPort
  import vid_reg_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  portOfs,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic [5:0]  evtIn,
  output logic        ramWrReq,
  input  logic        ramReady,
  output logic [15:0] ramWrAddr,
  output logic [15:0] ramWrData,
  output logic [15:0] ramRdAddr,
  input  logic [15:0] ramRdWord,
  output logic        dmaStart
);
  portStrobe_t strobe;

  vidRegPortCtrl uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .portOfs (portOfs),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .wrIdx   (wrData[IDX_W-1:0]),
    .strobe  (strobe)
  );

  vidRegPortData uData (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrData    (wrData),
    .rdData    (rdData),
    .evtIn     (evtIn),
    .ramWrReq  (ramWrReq),
    .ramReady  (ramReady),
    .ramWrAddr (ramWrAddr),
    .ramWrData (ramWrData),
    .ramRdAddr (ramRdAddr),
    .ramRdWord (ramRdWord),
    .dmaStart  (dmaStart)
  );
endmodule

// File: tb/vidRegPort_test.sv
module vidRegPort_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  portOfs = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [5:0]  evtIn = '0;
  logic        ramWrReq, ramReady = 1'b1, dmaStart;
  logic [15:0] ramWrAddr, ramWrData, ramRdAddr, ramRdWord;
  int          nChk = 0, nBad = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;
  assign ramRdWord = ramRdAddr ^ 16'h5A3C;

  vidRegPort uut (
    .clk(clk), .rst_n(rst_n), .portOfs(portOfs), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .evtIn(evtIn), .ramWrReq(ramWrReq),
    .ramReady(ramReady), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .ramRdAddr(ramRdAddr), .ramRdWord(ramRdWord), .dmaStart(dmaStart)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [1:0] ofs, input logic [7:0] d);
    @(negedge clk); portOfs = ofs; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic [1:0] ofs, output logic [7:0] d);
    @(negedge clk); portOfs = ofs; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic setReg(input logic [4:0] idx, input logic [15:0] v);
    cpuWrite(2'd0, {3'b000, idx});
    cpuWrite(2'd2, v[7:0]);
    cpuWrite(2'd3, v[15:8]);
  endtask

  task automatic testReset();
    check("R9 reset rdData", {8'h0, rdData}, 16'h0);
    check("R3 reset ramWrReq", {15'h0, ramWrReq}, 16'h0);
    check("R10 reset pointers", ramWrAddr | ramRdAddr, 16'h0);
    check("R6 reset dmaStart", {15'h0, dmaStart}, 16'h0);
  endtask

  task automatic testIndexAndOfs1();
    logic [7:0] d;
    cpuWrite(2'd0, 8'hE1);           // R1: selects index 1
    cpuWrite(2'd2, 8'h34);
    cpuWrite(2'd3, 8'h12);
    check("R1 R2 read pointer load", ramRdAddr, 16'h1234);
    cpuWrite(2'd1, 8'hFF);
    check("R9 offset1 write ignored rd", ramRdAddr, 16'h1234);
    check("R9 offset1 write ignored wr", ramWrAddr, 16'h0000);
    cpuRead(2'd1, d);
    check("R9 offset1 read zero", {8'h0, d}, 16'h0);
  endtask

  task automatic testRamWrite();
    setReg(5'h00, 16'h0100);
    cpuWrite(2'd0, 8'h02);
    cpuWrite(2'd2, 8'hCD);
    cpuWrite(2'd3, 8'hAB);
    check("R3 request raised", {15'h0, ramWrReq}, 16'h1);
    check("R3 request address", ramWrAddr, 16'h0100);
    check("R3 request word", ramWrData, 16'hABCD);
    @(negedge clk);
    check("R3 request dropped", {15'h0, ramWrReq}, 16'h0);
    check("R4 step 1 advance", ramWrAddr, 16'h0101);
    ramReady = 1'b0;
    cpuWrite(2'd2, 8'h22);
    cpuWrite(2'd3, 8'h11);
    repeat (3) @(negedge clk);
    check("R3 held while not ready", {15'h0, ramWrReq}, 16'h1);
    check("R3 held address", ramWrAddr, 16'h0101);
    check("R3 held word", ramWrData, 16'h1122);
    ramReady = 1'b1;
    @(negedge clk);
    check("R3 accepted", {15'h0, ramWrReq}, 16'h0);
    check("R4 advance after accept", ramWrAddr, 16'h0102);
  endtask

  task automatic testStrides();
    for (int s = 1; s < 4; s++) begin
      cpuWrite(2'd0, 8'h05);
      cpuWrite(2'd3, 8'(s << 3));
      setReg(5'h00, 16'h0200);
      setReg(5'h02, 16'h0F0F);
      @(negedge clk);
      check("R4 stride select", ramWrAddr, 16'h0200 + (16'd16 << s));
    end
  endtask

  task automatic testRamRead();
    logic [7:0] d;
    cpuWrite(2'd0, 8'h05); cpuWrite(2'd3, 8'h00);   // stride 1
    setReg(5'h01, 16'h2000);
    cpuRead(2'd2, d);
    check("R5 low byte", {8'h0, d}, 16'h003C);
    check("R5 low read keeps pointer", ramRdAddr, 16'h2000);
    cpuRead(2'd3, d);
    check("R5 high byte", {8'h0, d}, 16'h007A);
    check("R5 pointer step 1", ramRdAddr, 16'h2001);
    cpuWrite(2'd0, 8'h05); cpuWrite(2'd3, 8'h10);   // stride 64
    cpuRead(2'd3, d);
    check("R5 high byte second", {8'h0, d}, 16'h007A);
    check("R5 pointer step 64", ramRdAddr, 16'h2041);
  endtask

  task automatic testWrap();
    logic [7:0] d;
    cpuWrite(2'd0, 8'h05); cpuWrite(2'd3, 8'h00);
    setReg(5'h01, 16'hFFFF);
    cpuRead(2'd3, d);
    check("R10 read pointer wrap", ramRdAddr, 16'h0000);
    cpuWrite(2'd0, 8'h05); cpuWrite(2'd3, 8'h08);   // stride 32
    setReg(5'h00, 16'hFFF0);
    setReg(5'h02, 16'h1234);
    @(negedge clk);
    check("R10 write pointer wrap", ramWrAddr, 16'h0010);
  endtask

  task automatic testDma();
    cpuWrite(2'd0, 8'h12);
    cpuWrite(2'd2, 8'h40);
    check("R6 no pulse on low byte", {15'h0, dmaStart}, 16'h0);
    cpuWrite(2'd3, 8'h00);
    check("R6 pulse after high byte", {15'h0, dmaStart}, 16'h1);
    @(negedge clk);
    check("R6 pulse one cycle", {15'h0, dmaStart}, 16'h0);
  endtask

  task automatic testStatus();
    logic [7:0] d;
    cpuWrite(2'd0, 8'h0F); cpuWrite(2'd2, 8'h01);  // enable bit 3
    cpuWrite(2'd0, 8'h13); cpuWrite(2'd3, 8'h7F);
    cpuRead(2'd0, d);
    check("R7 sprite-table done flag", {8'h0, d}, 16'h0008);
    cpuRead(2'd0, d);
    check("R8 flag cleared by read", {8'h0, d}, 16'h0000);
    cpuWrite(2'd0, 8'h0F); cpuWrite(2'd2, 8'h00);
    @(negedge clk); evtIn = 6'h3F;
    @(negedge clk); evtIn = 6'h00;
    cpuRead(2'd0, d);
    check("R11 R8 masked when disabled", {8'h0, d}, 16'h0000);
    cpuWrite(2'd0, 8'h05); cpuWrite(2'd2, 8'h0F);
    cpuRead(2'd0, d);
    check("R8 R11 control enables map", {8'h0, d}, 16'h0027);
    cpuWrite(2'd0, 8'h0F); cpuWrite(2'd2, 8'h03);
    cpuRead(2'd0, d);
    check("R8 only returned bits cleared", {8'h0, d}, 16'h0018);
    cpuRead(2'd0, d);
    check("R8 all cleared", {8'h0, d}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testIndexAndOfs1();
    testRamWrite();
    testStrides();
    testRamRead();
    testWrap();
    testDma();
    testStatus();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule